// File: doc/BRIEF.md
# Register-Window Multiply-Accumulate Unit

This peripheral sits on a simple synchronous register bus and performs 16 x 16 bit multiplications, either as a plain product or summed into a 32-bit running total. Software writes the first operand to one of four word addresses. The address it uses picks the arithmetic flavour: unsigned or two's-complement, and multiply or multiply-accumulate. Writing the second operand to a single trigger address launches the operation using the stored first operand and the flavour selected last.

The outcome is read back as two 16-bit halves and an extension word. In the plain multiply flavours the halves come from the product register. In the accumulate flavours they come from the accumulator. The extension word gives the sign of a signed outcome, or the carry out of the most recent unsigned accumulate. The first operand is kept after a launch, so a series of trigger writes can reuse one coefficient.

Top module: `mac16_periph`

## Requirements
- R1: A word write to 0x130, 0x132, 0x134 or 0x136 stores the data as operand one and sets the flavour, in that address order, to unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. The address bits [2:1] carry the flavour code 0..3.
- R2: A write to 0x138 launches the operation with the written data as operand two. The outcome is readable in the cycle after that write.
- R3: The signed flavours treat both operands as two's-complement values. The unsigned flavours treat both operands as zero-extended values.
- R4: A multiply stores the 32-bit product, modulo 2^32, in the product register and clears the accumulator.
- R5: An accumulate adds the product to the accumulator modulo 2^32 and clears the product register. In the accumulate flavours, reads of 0x13A and 0x13C show the accumulator. In the multiply flavours they show the product register.
- R6: A read of 0x13A returns bits 15:0 of the selected 32-bit value. A read of 0x13C returns bits 31:16.
- R7: A read of 0x13E returns the extension word, which depends on the flavour:
  - unsigned multiply gives 0x0000;
  - signed multiply gives 0xFFFF when the product's bit 31 is set and 0x0000 otherwise;
  - signed accumulate gives 0xFFFF when the accumulator's bit 31 is set and 0x0000 otherwise;
  - unsigned accumulate gives 0x0001 when the last accumulate carried out of bit 31 and 0x0000 otherwise.
- R8: Only even addresses are valid. A write to an odd address, or to any address other than operand one or operand two, changes no state. A read of an odd or unmapped address returns 0x0000.
- R9: After a synchronous active-low reset, both operands, the product, the accumulator and the carry read as zero, and the flavour is unsigned multiply.
- R10: Operand one and the flavour survive a launch, so repeated writes to 0x138 accumulate further products with the same operand one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, combinational from the address and state |

## Verification
The assertions take two things for granted. First, the bus holds one stable address and write strobe per cycle. Second, the write strobe is never X while reset is released. Because of this, a launch is exactly one cycle of write strobe at 0x138, and the extension word can only take one of three legal values. The stimulus drives every bus signal on the falling edge, pulses the write strobe for exactly one cycle, and keeps reads and writes in separate cycles, so both conditions always hold.

// File: rtl/mac16_pkg.sv
// Shared types and register offsets for the multiply-accumulate window.
// Assumes byte addressing with 16-bit word accesses only.
package mac16_pkg;
    // Flavour code; its value equals address bits [2:1] of the operand-one write.
    typedef enum logic [1:0] {
        MODE_UMPY = 2'd0,
        MODE_SMPY = 2'd1,
        MODE_UMAC = 2'd2,
        MODE_SMAC = 2'd3
    } mac_mode_e;

    localparam logic [15:0] OFS_OP1_BASE = 16'h0130;
    localparam logic [15:0] OFS_OP2      = 16'h0138;
    localparam logic [15:0] OFS_RES_LO   = 16'h013A;
    localparam logic [15:0] OFS_RES_HI   = 16'h013C;
    localparam logic [15:0] OFS_EXT      = 16'h013E;

    function automatic logic mode_is_signed(input mac_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_is_acc(input mac_mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/mac16_regs.sv
// Write decoder and operand-one/flavour storage.
// Assumes one write per cycle; odd and foreign addresses are ignored.
module mac16_regs
    import mac16_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] op1_q,
    output mac_mode_e         mode_q,
    output logic              start
);
    localparam logic [ADDR_W-1:0] OP1_BASE = ADDR_W'(OFS_OP1_BASE);
    localparam logic [ADDR_W-1:0] OP2_ADDR = ADDR_W'(OFS_OP2);

    logic op1_hit;

    // Decode the two write targets.
    always_comb begin
        op1_hit = we && (addr[ADDR_W-1:3] == OP1_BASE[ADDR_W-1:3]) && !addr[0];
        start   = we && (addr == OP2_ADDR);
    end

    // Hold operand one and the flavour chosen by its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op1_q  <= '0;
            mode_q <= MODE_UMPY;
        end else if (op1_hit) begin
            op1_q  <= wdata;
            mode_q <= mac_mode_e'(addr[2:1]);
        end
    end

    a_r1_smpy_select: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OP1_BASE + ADDR_W'(2)) |=> (mode_q == MODE_SMPY && op1_q == $past(wdata)));
    a_r8_odd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr[0]) |=> ($stable(op1_q) && $stable(mode_q)));
    a_r10_op1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> $stable(op1_q));
endmodule

// File: rtl/mac16_core.sv
// Multiplier with product and accumulator registers.
// Assumes start is a one-cycle pulse with operand two valid alongside it.
module mac16_core
    import mac16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  mac_mode_e           mode,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    output logic [2*DATA_W-1:0] res_q,
    output logic [2*DATA_W-1:0] acc_q,
    output logic                carry_q
);
    localparam int PROD_W = 2 * DATA_W;

    logic              sgn;
    logic [PROD_W-1:0] ext_a, ext_b, prod;
    logic [PROD_W:0]   sum;

    // Extend operands by flavour, form the product and the accumulate sum.
    always_comb begin
        sgn   = mode_is_signed(mode);
        ext_a = {{DATA_W{sgn & op_a[DATA_W-1]}}, op_a};
        ext_b = {{DATA_W{sgn & op_b[DATA_W-1]}}, op_b};
        prod  = PROD_W'(ext_a * ext_b);
        sum   = {1'b0, acc_q} + {1'b0, prod};
    end

    // Update either the product register or the accumulator on a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (start) begin
            if (mode_is_acc(mode)) begin
                acc_q   <= sum[PROD_W-1:0];
                carry_q <= sum[PROD_W];
                res_q   <= '0;
            end else begin
                res_q   <= prod;
                acc_q   <= '0;
                carry_q <= 1'b0;
            end
        end
    end

    a_r4_mpy_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode[1]) |=> (acc_q == '0 && !carry_q));
    a_r5_mac_clears_res: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode[1]) |=> (res_q == '0));
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_q) && $stable(res_q) && $stable(carry_q)));
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && res_q == '0 && !carry_q));
endmodule

// File: rtl/mac16_rdmux.sv
// Read-data selection for the result and extension words.
// Assumes the flavour register reflects the most recent operand-one write.
module mac16_rdmux
    import mac16_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  mac_mode_e           mode,
    input  logic [2*DATA_W-1:0] res,
    input  logic [2*DATA_W-1:0] acc,
    input  logic                carry,
    output logic [DATA_W-1:0]   rdata
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] shown;
    logic [DATA_W-1:0] ext_word;

    // Pick the visible 32-bit value and build the extension word.
    always_comb begin
        shown = mode_is_acc(mode) ? acc : res;
        unique case (mode)
            MODE_UMPY: ext_word = '0;
            MODE_SMPY: ext_word = {DATA_W{res[PROD_W-1]}};
            MODE_UMAC: ext_word = DATA_W'(carry);
            MODE_SMAC: ext_word = {DATA_W{acc[PROD_W-1]}};
            default:   ext_word = '0;
        endcase
    end

    // Address decode of the read port.
    always_comb begin
        if (addr == ADDR_W'(OFS_RES_LO))      rdata = shown[DATA_W-1:0];
        else if (addr == ADDR_W'(OFS_RES_HI)) rdata = shown[PROD_W-1:DATA_W];
        else if (addr == ADDR_W'(OFS_EXT))    rdata = ext_word;
        else                                  rdata = '0;
    end

    a_r7_ext_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_EXT)) |-> (rdata == '0 || rdata == '1 || rdata == DATA_W'(1)));
    a_r8_odd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr[0] |-> (rdata == '0));
endmodule

// File: rtl/mac16_periph.sv
// Top of the multiply-accumulate register window: decoder, arithmetic core
// and read multiplexer. Assumes word accesses on a single-cycle bus.
module mac16_periph
    import mac16_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] op1_q;
    mac_mode_e         mode_q;
    logic              start;
    logic [PROD_W-1:0] res_q, acc_q;
    logic              carry_q;

    mac16_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .op1_q(op1_q), .mode_q(mode_q), .start(start)
    );

    mac16_core #(.DATA_W(DATA_W)) core_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_q),
        .op_a(op1_q), .op_b(bus_wdata),
        .res_q(res_q), .acc_q(acc_q), .carry_q(carry_q)
    );

    mac16_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rdmux_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .mode(mode_q),
        .res(res_q), .acc(acc_q), .carry(carry_q), .rdata(bus_rdata)
    );
endmodule

// File: tb/mac16_periph_tb.sv
module mac16_periph_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    typedef struct packed {
        logic [15:0] op1_addr;
        logic [15:0] a, b, lo, hi, ext;
    } vec_t;

    // Single operations from a cleared accumulator: R1 R3 R4 R6 R7.
    localparam vec_t VECS [10] = '{
        '{16'h0130, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 16'h0000},
        '{16'h0132, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000},
        '{16'h0132, 16'h8000, 16'h8000, 16'h0000, 16'h4000, 16'h0000},
        '{16'h0132, 16'h8000, 16'h0001, 16'h8000, 16'hFFFF, 16'hFFFF},
        '{16'h0130, 16'h8000, 16'h8000, 16'h0000, 16'h4000, 16'h0000},
        '{16'h0132, 16'h7FFF, 16'h8000, 16'h8000, 16'hC000, 16'hFFFF},
        '{16'h0130, 16'h0100, 16'h0100, 16'h0000, 16'h0001, 16'h0000},
        '{16'h0132, 16'h0003, 16'hFFFE, 16'hFFFA, 16'hFFFF, 16'hFFFF},
        '{16'h0134, 16'h0002, 16'h0003, 16'h0006, 16'h0000, 16'h0000},
        '{16'h0136, 16'hFFFF, 16'h0002, 16'hFFFE, 16'hFFFF, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac16_periph dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic chk(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic clear_acc();
        wr(16'h0130, 16'h0000);
        wr(16'h0138, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, flavour unsigned multiply
        chk(16'h013A, 16'h0000, "R9 lo");
        chk(16'h013C, 16'h0000, "R9 hi");
        chk(16'h013E, 16'h0000, "R9 ext");

        // Vector table walk
        for (int i = 0; i < 10; i++) begin
            clear_acc();
            wr(VECS[i].op1_addr, VECS[i].a);
            wr(16'h0138, VECS[i].b);
            chk(16'h013A, VECS[i].lo, "R6 lo vec");
            chk(16'h013C, VECS[i].hi, "R6 hi vec");
            chk(16'h013E, VECS[i].ext, "R7 ext vec");
        end

        // R2: outcome visible the cycle after the trigger write
        clear_acc();
        wr(16'h0130, 16'h0007);
        @(negedge clk);
        bus_addr = 16'h0138; bus_wdata = 16'h0003; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 16'h013A;
        #1; checks++;
        if (bus_rdata !== 16'h0015) begin
            errors++;
            $display("FAIL R2 next-cycle actual=%h expected=%h", bus_rdata, 16'h0015);
        end

        // R10 and R7: unsigned accumulate with carry, operand one reused
        clear_acc();
        wr(16'h0134, 16'hFFFF);
        wr(16'h0138, 16'hFFFF);
        wr(16'h0138, 16'hFFFF);
        chk(16'h013A, 16'h0002, "R10 lo");
        chk(16'h013C, 16'hFFFC, "R10 hi");
        chk(16'h013E, 16'h0001, "R7 carry");
        wr(16'h0138, 16'h0001);
        chk(16'h013C, 16'hFFFD, "R5 hi");
        chk(16'h013A, 16'h0001, "R5 lo");
        chk(16'h013E, 16'h0000, "R7 no carry");

        // R5 and R3: signed accumulate wrapping past 2^31
        clear_acc();
        wr(16'h0136, 16'h8000);
        wr(16'h0138, 16'h8000);
        wr(16'h0138, 16'h8000);
        chk(16'h013C, 16'h8000, "R5 wrap hi");
        chk(16'h013A, 16'h0000, "R5 wrap lo");
        chk(16'h013E, 16'hFFFF, "R7 smac neg");
        wr(16'h0136, 16'hFFFF);
        wr(16'h0138, 16'h0001);
        chk(16'h013C, 16'h7FFF, "R3 smac hi");
        chk(16'h013A, 16'hFFFF, "R3 smac lo");
        chk(16'h013E, 16'h0000, "R7 smac pos");

        // R4: a multiply clears the accumulator
        wr(16'h0130, 16'h0002);
        wr(16'h0138, 16'h0002);
        chk(16'h013A, 16'h0004, "R4 product");
        wr(16'h0134, 16'h0000);
        wr(16'h0138, 16'h0000);
        chk(16'h013C, 16'h0000, "R4 acc hi cleared");
        chk(16'h013A, 16'h0000, "R4 acc lo cleared");

        // R5: an accumulate clears the product register
        wr(16'h0130, 16'h0005);
        wr(16'h0138, 16'h0005);
        chk(16'h013A, 16'h0019, "R5 product");
        wr(16'h0136, 16'h0001);
        wr(16'h0138, 16'h0001);
        chk(16'h013A, 16'h0001, "R5 acc view");
        wr(16'h0130, 16'h0000);
        chk(16'h013A, 16'h0000, "R5 product cleared");

        // R8: odd and foreign writes change nothing; odd/unmapped reads are zero
        wr(16'h0130, 16'h0003);
        wr(16'h0138, 16'h0003);
        wr(16'h0139, 16'h0005);
        wr(16'h0131, 16'h0009);
        wr(16'h013A, 16'h1234);
        wr(16'h0200, 16'h0004);
        chk(16'h013A, 16'h0009, "R8 writes ignored");
        chk(16'h013E, 16'h0000, "R8 flavour kept");
        chk(16'h013B, 16'h0000, "R8 odd read");
        chk(16'h0200, 16'h0000, "R8 unmapped read");
        wr(16'h0138, 16'h0002);
        chk(16'h013A, 16'h0006, "R8 op1 kept");

        // R9: reset mid-run clears everything and restores unsigned multiply
        wr(16'h0136, 16'hFFFF);
        wr(16'h0138, 16'h0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(16'h013E, 16'h0000, "R9 ext after reset");
        chk(16'h013C, 16'h0000, "R9 hi after reset");
        wr(16'h0138, 16'h0004);
        chk(16'h013A, 16'h0000, "R9 op1 cleared");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule